// File: doc/BRIEF.md
# Burst-Capable External Bus Slave

This block answers transfers on a synchronous 32-bit external bus that has separate address, data and control lines. When the master pulls the active-low start strobe low, the slave captures the direction, transfer size, burst flag and address. It then serves the transfer from a small internal array of 32-bit words. Each data beat is closed with an active-low acknowledge. The acknowledge line is shared with other slaves. For that reason the block has an output enable for it, and the line is actively driven high for one cycle before that enable is released.

A burst has no fixed length. During each acknowledged beat the master drives a "more beats follow" input. If it is high, another beat comes; if it is low, that beat is the last. Burst beats move through word addresses and wrap inside an aligned four-word block. A configurable number of wait cycles comes before every acknowledge.

The control path is one state machine with four states:
- `IDLE`: the block watches the start strobe.
- `WAIT`: the block counts wait cycles.
- `ACK`: the acknowledge is asserted for one beat.
- `RELEASE`: the acknowledge is driven high one last time.

Its transitions are:
- IDLE→WAIT, or IDLE→ACK when there are no wait cycles, on a sampled start.
- WAIT→ACK when the wait count is done.
- ACK→WAIT or ACK→ACK to continue a burst.
- ACK→RELEASE on the last beat.
- RELEASE→IDLE.

Top module: `burst_bus_slave`

## Requirements
- R1: After reset, `ack_n` is 1 and `ack_oe` and `rd_oe` are 0, and every storage word reads as zero.
- R2: A low `start_n` sampled in IDLE begins a transfer. Acknowledge is then asserted after exactly WAIT_CYCLES further cycles, in the cycle after the last wait cycle. `start_n` is ignored in every other state.
- R3: An acknowledged write (`rd_not_wr`=0) updates only the enabled byte lanes of the addressed word, taking them from the same lanes of `wdata`.
- R4: During an acknowledged read beat, `rdata` holds the addressed word with disabled lanes forced to zero. `rd_oe` is 1 only in read acknowledge cycles.
- R5: Size codes are 00=word, 01=byte, 10=half-word and 11=word. Address bits [1:0] select lanes big-endian: offset 0 is `data[31:24]`, and half-word offset bit 1 = 0 is `data[31:16]`.
- R6: After the last acknowledge, the next cycle has `ack_n`=1 with `ack_oe`=1, and the cycle after that has `ack_oe`=0. `ack_oe` is 1 from the first cycle after start through the release cycle.
- R7: In a burst, `more_beats`=1 at an acknowledged beat causes another beat. `more_beats`=0 makes that beat the last. For a non-burst transfer, `more_beats` has no effect.
- R8: Beat k of a burst accesses word ((start_word + k) mod 4) inside the aligned four-word block that holds the start address.
- R9: Burst beats always move full 32-bit words, whatever the size field.
- R10: Every beat, including each later burst beat, is preceded by WAIT_CYCLES cycles with `ack_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n | input | 1 | Active-low transfer start strobe |
| rd_not_wr | input | 1 | 1 = read from slave, 0 = write to slave |
| xfer_size | input | 2 | Transfer size code |
| is_burst | input | 1 | Transfer is a burst, valid with start |
| more_beats | input | 1 | Another burst beat follows the current one |
| addr | input | WORD_AW+2 | Byte address, stable until acknowledge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| rd_oe | output | 1 | Read data output enable |
| ack_n | output | 1 | Active-low transfer acknowledge |
| ack_oe | output | 1 | Acknowledge output enable |

## Verification
The hardest case to reach is a burst whose start word is not the first word of its block and that runs past the wrap point, combined with a "more" signal that changes between beats. On top of that, wait cycles must separate the beats. The stimulus uses one wait cycle and runs bursts from every start word, with lengths from one to four beats. The `more_beats` input is updated only after each acknowledge edge, so every beat sees the right value. A non-burst transfer is also sent with `more_beats` held high, and the start strobe is held low through a busy transfer, to show that both are ignored.

// File: rtl/bus_slv_pkg.sv
package bus_slv_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_WAIT    = 2'd1,
        S_ACK     = 2'd2,
        S_RELEASE = 2'd3
    } slv_state_t;

    // Big-endian lane enables: bit 3 is data[31:24].
    function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lo);
        logic [3:0] m;
        unique case (size)
            2'b01:   m = 4'b1000 >> lo;
            2'b10:   m = lo[1] ? 4'b0011 : 4'b1100;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bus_slv_regfile.sv
module bus_slv_regfile #(
    parameter int WORD_AW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_AW-1:0] idx,
    input  logic [3:0]         be,
    input  logic [31:0]        wdata,
    output logic [31:0]        rword
);
    localparam int NWORDS = 1 << WORD_AW;

    logic [31:0] mem [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        for (genvar l = 0; l < 4; l++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[w][8*l +: 8] <= '0;
                else if (wr_en && be[l] && idx == WORD_AW'(w))
                    mem[w][8*l +: 8] <= wdata[8*l +: 8];
            end
        end
    end

    assign rword = mem[idx];

endmodule

// File: rtl/bus_slv_lanes.sv
module bus_slv_lanes (
    input  logic [31:0] rword,
    input  logic [3:0]  be,
    input  logic        oe,
    output logic [31:0] rdata
);
    always_comb begin
        for (int l = 0; l < 4; l++)
            rdata[8*l +: 8] = (oe && be[l]) ? rword[8*l +: 8] : 8'h00;
    end
endmodule

// File: rtl/bus_slv_fsm.sv
module bus_slv_fsm
    import bus_slv_pkg::*;
#(
    parameter int WORD_AW     = 3,
    parameter int WAIT_CYCLES = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_n,
    input  logic               rd_not_wr,
    input  logic [1:0]         xfer_size,
    input  logic               is_burst,
    input  logic               more_beats,
    input  logic [WORD_AW+1:0] addr,
    output logic [WORD_AW-1:0] idx,
    output logic [3:0]         be,
    output logic               wr_en,
    output logic               rd_oe,
    output logic               ack_n,
    output logic               ack_oe
);
    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] WAIT_LAST = (WAIT_CYCLES > 0) ? CW'(WAIT_CYCLES - 1) : '0;
    localparam slv_state_t BEAT_ENTRY = (WAIT_CYCLES == 0) ? S_ACK : S_WAIT;

    slv_state_t state_q, state_d;
    logic [CW-1:0]      wcnt_q;
    logic               rd_q, burst_q;
    logic [1:0]         size_q, lo_q;
    logic [WORD_AW-1:0] idx_q;
    logic               continue_burst;

    assign continue_burst = burst_q && more_beats;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (!start_n) state_d = BEAT_ENTRY;
            S_WAIT:    if (wcnt_q == WAIT_LAST) state_d = S_ACK;
            S_ACK:     state_d = continue_burst ? BEAT_ENTRY : S_RELEASE;
            S_RELEASE: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wcnt_q  <= '0;
            rd_q    <= 1'b0;
            burst_q <= 1'b0;
            size_q  <= 2'b00;
            lo_q    <= 2'b00;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_WAIT) wcnt_q <= wcnt_q + 1'b1;
            else                   wcnt_q <= '0;
            if (state_q == S_IDLE && !start_n) begin
                rd_q    <= rd_not_wr;
                burst_q <= is_burst;
                size_q  <= xfer_size;
                lo_q    <= addr[1:0];
                idx_q   <= addr[WORD_AW+1:2];
            end else if (state_q == S_ACK && continue_burst) begin
                idx_q[1:0] <= idx_q[1:0] + 2'd1;
            end
        end
    end

    always_comb begin
        idx    = idx_q;
        be     = burst_q ? 4'b1111 : lane_mask(size_q, lo_q);
        ack_n  = (state_q != S_ACK);
        ack_oe = (state_q != S_IDLE);
        rd_oe  = (state_q == S_ACK) && rd_q;
        wr_en  = (state_q == S_ACK) && !rd_q;
    end

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start_n) |=> (state_q == BEAT_ENTRY));
    p_busy_ignores_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELEASE) |=> (state_q == S_IDLE));
    p_rdoe_only_read_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (!ack_n && rd_q));
    p_ack_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> ack_oe);
    p_release_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !continue_burst) |=> (ack_n && ack_oe));
    p_release_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELEASE) |=> !ack_oe);
    p_burst_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && continue_burst) |=>
            (idx_q[WORD_AW-1:2] == $past(idx_q[WORD_AW-1:2]) &&
             idx_q[1:0] == $past(idx_q[1:0]) + 2'd1));
    p_burst_full_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_q && state_q != S_IDLE) |-> (be == 4'b1111));

endmodule

// File: rtl/burst_bus_slave.sv
module burst_bus_slave #(
    parameter int WORD_AW     = 3,
    parameter int WAIT_CYCLES = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_n,
    input  logic               rd_not_wr,
    input  logic [1:0]         xfer_size,
    input  logic               is_burst,
    input  logic               more_beats,
    input  logic [WORD_AW+1:0] addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               rd_oe,
    output logic               ack_n,
    output logic               ack_oe
);
    logic [WORD_AW-1:0] idx;
    logic [3:0]         be;
    logic               wr_en;
    logic [31:0]        rword;

    bus_slv_fsm #(.WORD_AW(WORD_AW), .WAIT_CYCLES(WAIT_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .rd_not_wr(rd_not_wr),
        .xfer_size(xfer_size), .is_burst(is_burst), .more_beats(more_beats),
        .addr(addr), .idx(idx), .be(be), .wr_en(wr_en), .rd_oe(rd_oe),
        .ack_n(ack_n), .ack_oe(ack_oe)
    );

    bus_slv_regfile #(.WORD_AW(WORD_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .be(be),
        .wdata(wdata), .rword(rword)
    );

    bus_slv_lanes u_lanes (
        .rword(rword), .be(be), .oe(rd_oe), .rdata(rdata)
    );

    p_write_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!ack_n && !rd_oe));

endmodule

// File: tb/burst_bus_slave_test.sv
module burst_bus_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAW = 3;
    localparam int WS  = 1;
    localparam int NW  = 1 << WAW;

    logic clk = 0, rst_n = 0;
    logic start_n = 1, rd_not_wr = 0, is_burst = 0, more_beats = 0;
    logic [1:0] xfer_size = 0;
    logic [WAW+1:0] addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic rd_oe, ack_n, ack_oe;

    int checks = 0, errors = 0;
    logic [31:0] model [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_bus_slave #(.WORD_AW(WAW), .WAIT_CYCLES(WS)) uut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .rd_not_wr(rd_not_wr),
        .xfer_size(xfer_size), .is_burst(is_burst), .more_beats(more_beats),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe),
        .ack_n(ack_n), .ack_oe(ack_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_mask(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'b01) return 32'hFF00_0000 >> (8 * lo);
        if (sz == 2'b10) return 32'hFFFF_0000 >> (16 * lo[1]);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] seed, input int b);
        return seed ^ (32'h1357_9BDF * (b + 1));
    endfunction

    // One transfer of nb beats; force_more holds more_beats high (non-burst R7 check)
    task automatic xfer(input bit rd, input bit bu, input logic [1:0] sz,
                        input logic [WAW+1:0] a, input int nb, input logic [31:0] seed,
                        input bit force_more, input string tag);
        int w, waits;
        logic [31:0] m;
        @(negedge clk);
        start_n = 0; rd_not_wr = rd; is_burst = bu; xfer_size = sz; addr = a;
        wdata = pat(seed, 0); more_beats = force_more || (nb > 1);
        @(negedge clk);
        start_n = 1;
        for (int b = 0; b < nb; b++) begin
            waits = 0;
            while (ack_n && waits < 8) begin
                chk(ack_oe == 1 && rd_oe == 0, "R6 oe during wait", {30'd0, ack_oe, rd_oe}, 32'd2);
                @(negedge clk); waits++;
            end
            chk(waits == WS, "R10/R2 wait cycles before ack", waits, WS);
            w = bu ? (((int'(a) >> 2) & ~3) | (((int'(a) >> 2) + b) & 3)) : (int'(a) >> 2);
            m = bu ? 32'hFFFF_FFFF : exp_mask(sz, a[1:0]);
            if (rd) begin
                chk(rd_oe == 1, {tag, " R4 rd_oe"}, rd_oe, 1);
                chk(rdata == (model[w] & m), {tag, " R4/R5/R8/R9 rdata"}, rdata, model[w] & m);
            end else begin
                chk(rd_oe == 0, {tag, " R4 rd_oe on write"}, rd_oe, 0);
                model[w] = (model[w] & ~m) | (pat(seed, b) & m);
            end
            @(negedge clk);
            wdata = pat(seed, b + 1);
            more_beats = force_more || (b + 2 < nb);
        end
        chk(ack_n == 1 && ack_oe == 1, {tag, " R6/R7 release cycle"}, {30'd0, ack_n, ack_oe}, 32'd3);
        @(negedge clk);
        chk(ack_oe == 0, {tag, " R6 oe dropped"}, ack_oe, 0);
        more_beats = 0;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        chk(ack_n == 1 && ack_oe == 0 && rd_oe == 0, "R1 outputs in reset", {29'd0, ack_n, ack_oe, rd_oe}, 32'd4);
        rst_n = 1;
        for (int w = 0; w < NW; w++) xfer(1, 0, 2'b00, (WAW+2)'(w*4), 1, 0, 0, "R1 zero");

        // byte writes at every lane, then full reads (R3, R5)
        for (int w = 0; w < NW; w++)
            for (int o = 0; o < 4; o++)
                xfer(0, 0, 2'b01, (WAW+2)'(w*4+o), 1, 32'hA5C3_0000 + w*16 + o, 0, "R3 byte wr");
        for (int w = 0; w < NW; w++) xfer(1, 0, 2'b00, (WAW+2)'(w*4), 1, 0, 0, "R3 word rd");
        // half writes, reserved-code word writes, reads of every size/offset
        for (int w = 0; w < NW; w++)
            for (int o = 0; o < 4; o += 2)
                xfer(0, 0, 2'b10, (WAW+2)'(w*4+o), 1, 32'h6B00_1000 + w*7 + o, 0, "R5 half wr");
        xfer(0, 0, 2'b11, 5'd8, 1, 32'hDEAD_BEEF, 0, "R5 code11 wr");
        for (int w = 0; w < NW; w++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 4; s++)
                    xfer(1, 0, 2'(s), (WAW+2)'(w*4+o), 1, 0, 0, "R5 sized rd");

        // bursts from every start word, 1..4 beats, byte size field (R7, R8, R9)
        for (int w = 0; w < NW; w++)
            for (int n = 1; n <= 4; n++) begin
                xfer(0, 1, 2'b01, (WAW+2)'(w*4+1), n, 32'h0F0F_0000 + w*256 + n, 0, "R8 burst wr");
                xfer(1, 1, 2'b10, (WAW+2)'(w*4), n, 0, 0, "R8 burst rd");
            end
        for (int w = 0; w < NW; w++) xfer(1, 0, 2'b00, (WAW+2)'(w*4), 1, 0, 0, "R9 verify");

        // non-burst ignores more_beats (R7)
        xfer(0, 0, 2'b00, 5'd12, 1, 32'h7777_0000, 1, "R7 nonburst more");
        xfer(1, 0, 2'b00, 5'd12, 1, 0, 1, "R7 nonburst more rd");
        xfer(1, 0, 2'b00, 5'd16, 1, 0, 0, "R7 neighbour untouched");

        // start held low while busy is ignored (R2)
        @(negedge clk);
        start_n = 0; rd_not_wr = 1; is_burst = 0; xfer_size = 0; addr = 5'd4;
        @(negedge clk);
        chk(ack_n == 1, "R2 wait cycle", ack_n, 1);
        @(negedge clk);
        chk(ack_n == 0 && rdata == model[1], "R2 ack data", rdata, model[1]);
        @(negedge clk);
        start_n = 1;
        chk(ack_n == 1 && ack_oe == 1, "R2 release", {31'd0, ack_oe}, 1);
        @(negedge clk);
        chk(ack_oe == 0, "R2 no restart", ack_oe, 0);
        @(negedge clk);
        chk(ack_oe == 0, "R2 still idle", ack_oe, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule